// File: doc/BRIEF.md
# Register-Mapped Streaming Load/Store Unit

This unit links a processor to memory through a small set of data registers. Each register has a FIFO on both sides. A load command names a register, a base address, a signed stride and an element count. A per-register stream engine then sends one read request per cycle to memory for as long as that register has space reserved. Each returned word is pushed into the register's load FIFO, and every scalar read of the register takes the next element. A single scalar load is a stream with a count of one.

Stores are split in two halves. A store address, tagged with its register, goes into one shared store-address queue. The store data reaches the unit later, when the processor writes the register, and is pushed into that register's store-data FIFO. A write request goes to memory only when the oldest queued address and the oldest data word of the same register are both present. Both are then consumed in the same cycle.

The memory side has a request/acknowledge port. Read responses come back in order, each carrying the tag of its destination register. Accesses to different registers are not ordered against each other.

Top module: `ldsf_unit`

## Requirements
- R1: After reset no memory request is raised, no stream is busy, the store-address queue is not full, and neither stall output is high.
- R2: A started stream issues exactly `count` read requests, at addresses base, base+stride, base+2·stride, and so on, modulo 2^AW, with stride taken as two's complement. Its busy bit stays high until the last request is acknowledged. A count of zero starts nothing.
- R3: A register's stream raises a read request only while the entries in its load FIFO plus its reads still outstanding number fewer than LDEPTH.
- R4: A read response with tag r is appended to register r's load FIFO. Reading register r returns those words in arrival order.
- R5: Reading a register whose load FIFO is empty raises `rd_stall` in that same cycle and removes nothing.
- R6: Writing a register pushes the word into its store-data FIFO. Writing while that FIFO holds SDEPTH words raises `wr_stall` in that cycle, and the word is dropped.
- R7: A write request (`mem_we`=1) is raised only when the store-address queue is non-empty and the store-data FIFO of the register tagged at its head is non-empty. It carries that head address, that data word and that register as `mem_tag`. On acknowledge, both heads are removed.
- R8: When several sources are ready, a pending store has priority over stream reads, and among streams the lower register number wins. At most one source is granted per cycle.
- R9: A start command for a register whose stream is busy is ignored. The running stream continues unchanged.
- R10: While the store-address queue holds SAQ_DEPTH entries, `sa_full` is high and a new address push is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_start | input | 1 | Start a load stream |
| ld_reg | input | RW | Register the stream fills |
| ld_base | input | AW | First element address |
| ld_stride | input | AW | Signed address step |
| ld_count | input | CW | Number of elements |
| ld_busy | output | NREG | Stream active, one bit per register |
| sa_valid | input | 1 | Push a store address |
| sa_reg | input | RW | Register whose data the store takes |
| sa_addr | input | AW | Store address |
| sa_full | output | 1 | Store-address queue full |
| rd_en | input | 1 | Scalar read of a register |
| rd_reg | input | RW | Register read |
| rd_data | output | DW | Head of that register's load FIFO |
| rd_stall | output | 1 | Read found the FIFO empty |
| wr_en | input | 1 | Scalar write of a register |
| wr_reg | input | RW | Register written |
| wr_data | input | DW | Store data |
| wr_stall | output | 1 | Write found the store-data FIFO full |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data (zero on reads) |
| mem_tag | output | RW | Register the request belongs to |
| mem_ack | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rtag | input | RW | Register the response belongs to |
| mem_rdata | input | DW | Response data |

## Verification
The stall outputs and the request outputs are combinational from the registered state and the current inputs, so they are due in the cycle of the stimulus. Any change of state caused by a grant, a response, a read or a write becomes visible one edge later. A read response therefore cannot be read back before the cycle after it arrives. The bench drives each cycle's inputs just after a rising edge and lets them settle. It then computes the expected outputs from a queue-based model of the current cycle and compares. Only after that does it advance the model with the same inputs and the computed grant, so every comparison falls in the cycle where the result is due.

// File: rtl/ldsf_pkg.sv
package ldsf_pkg;
   typedef enum logic [1:0] {
      SRC_IDLE  = 2'd0,
      SRC_STORE = 2'd1,
      SRC_LOAD  = 2'd2
   } ldsf_src_e;
endpackage

// File: rtl/ldsf_fifo.sv
module ldsf_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]   count,
   output logic                         empty,
   output logic                         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNW = $clog2(DEPTH+1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ldsf_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]   slot_q [DEPTH];
   logic [PW-1:0]  wptr_q, rptr_q;
   logic [CNW-1:0] cnt_q;

   function automatic logic [PW-1:0] step_ptr(input logic [PW-1:0] p);
      return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (push) slot_q[wptr_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wptr_q <= step_ptr(wptr_q);
         if (pop)  rptr_q <= step_ptr(rptr_q);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + CNW'(1);
            2'b01:   cnt_q <= cnt_q - CNW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout  = slot_q[rptr_q];
   assign count = cnt_q;
   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CNW'(DEPTH));

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (!full || pop)); // R3
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R5
endmodule

// File: rtl/ldsf_stream.sv
module ldsf_stream #(
   parameter int AW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] stride,
   input  logic [CW-1:0] count,
   input  logic          room,
   input  logic          grant,
   output logic          busy,
   output logic          req,
   output logic [AW-1:0] addr
);
   logic [AW-1:0] addr_q, stride_q;
   logic [CW-1:0] left_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q   <= '0;
         stride_q <= '0;
         left_q   <= '0;
      end else if (start && !busy) begin
         addr_q   <= base;
         stride_q <= stride;
         left_q   <= count;
      end else if (grant) begin
         addr_q <= addr_q + stride_q;
         left_q <= left_q - CW'(1);
      end
   end

   assign busy = (left_q != '0);
   assign req  = busy && room;
   assign addr = addr_q;

   AST_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && busy) |=> (left_q == $past(left_q) - CW'($past(grant)))); // R9
   AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> req); // R3
endmodule

// File: rtl/ldsf_unit.sv
module ldsf_unit #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int NREG      = 2,
   parameter int LDEPTH    = 4,
   parameter int SDEPTH    = 4,
   parameter int SAQ_DEPTH = 4,
   parameter int CW        = 16,
   localparam int RW       = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld_start,
   input  logic [RW-1:0]   ld_reg,
   input  logic [AW-1:0]   ld_base,
   input  logic [AW-1:0]   ld_stride,
   input  logic [CW-1:0]   ld_count,
   output logic [NREG-1:0] ld_busy,
   input  logic            sa_valid,
   input  logic [RW-1:0]   sa_reg,
   input  logic [AW-1:0]   sa_addr,
   output logic            sa_full,
   input  logic            rd_en,
   input  logic [RW-1:0]   rd_reg,
   output logic [DW-1:0]   rd_data,
   output logic            rd_stall,
   input  logic            wr_en,
   input  logic [RW-1:0]   wr_reg,
   input  logic [DW-1:0]   wr_data,
   output logic            wr_stall,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   output logic [RW-1:0]   mem_tag,
   input  logic            mem_ack,
   input  logic            mem_rvalid,
   input  logic [RW-1:0]   mem_rtag,
   input  logic [DW-1:0]   mem_rdata
);
   import ldsf_pkg::*;

   localparam int LCW = $clog2(LDEPTH+1);
   localparam int SCW = $clog2(SDEPTH+1);
   localparam int QCW = $clog2(SAQ_DEPTH+1);
   localparam int QW  = RW + AW;

   if (NREG < 2 || NREG != (1 << RW)) begin : g_bad_nreg
      $error("ldsf_unit: NREG must be a power of two, at least 2");
   end
   if (CW < 1 || AW < 2 || DW < 1) begin : g_bad_width
      $error("ldsf_unit: widths out of range");
   end

   // per-register load side
   logic [NREG-1:0] lf_push, lf_pop, lf_empty, lf_full;
   logic [DW-1:0]   lf_head [NREG];
   logic [LCW-1:0]  lf_cnt  [NREG];
   logic [LCW-1:0]  infl_q  [NREG];
   logic [NREG-1:0] eng_req, eng_room, ld_grant;
   logic [AW-1:0]   eng_addr [NREG];

   // per-register store side
   logic [NREG-1:0] sd_push, sd_pop, sd_empty, sd_full;
   logic [DW-1:0]   sd_head [NREG];
   logic [SCW-1:0]  sd_cnt  [NREG];

   // shared store-address queue
   logic [QW-1:0]   sa_head;
   logic [QCW-1:0]  sa_cnt;
   logic            sa_empty, sa_push, st_ready, st_grant;
   logic [RW-1:0]   sa_head_reg;
   logic [AW-1:0]   sa_head_addr;
   ldsf_src_e       src;
   logic [RW-1:0]   ld_sel;

   assign sa_push      = sa_valid && !sa_full;
   assign sa_head_reg  = sa_head[QW-1 -: RW];
   assign sa_head_addr = sa_head[AW-1:0];
   assign st_ready     = !sa_empty && !sd_empty[sa_head_reg];
   assign st_grant     = (src == SRC_STORE) && mem_ack;

   ldsf_fifo #(.W(QW), .DEPTH(SAQ_DEPTH)) u_saq (
      .clk(clk), .rst_n(rst_n), .push(sa_push), .din({sa_reg, sa_addr}),
      .pop(st_grant), .dout(sa_head), .count(sa_cnt), .empty(sa_empty),
      .full(sa_full));

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic ret, start_r;
      logic [LCW:0] occ;

      assign ret        = mem_rvalid && (mem_rtag == RW'(r));
      assign lf_push[r] = ret;
      assign lf_pop[r]  = rd_en && (rd_reg == RW'(r)) && !lf_empty[r];
      assign sd_push[r] = wr_en && (wr_reg == RW'(r)) && !sd_full[r];
      assign sd_pop[r]  = st_grant && (sa_head_reg == RW'(r));
      assign occ        = {1'b0, lf_cnt[r]} + {1'b0, infl_q[r]};
      assign eng_room[r] = (occ < (LCW+1)'(LDEPTH));
      assign start_r    = ld_start && (ld_reg == RW'(r));

      ldsf_fifo #(.W(DW), .DEPTH(LDEPTH)) u_lfifo (
         .clk(clk), .rst_n(rst_n), .push(lf_push[r]), .din(mem_rdata),
         .pop(lf_pop[r]), .dout(lf_head[r]), .count(lf_cnt[r]),
         .empty(lf_empty[r]), .full(lf_full[r]));

      ldsf_fifo #(.W(DW), .DEPTH(SDEPTH)) u_sfifo (
         .clk(clk), .rst_n(rst_n), .push(sd_push[r]), .din(wr_data),
         .pop(sd_pop[r]), .dout(sd_head[r]), .count(sd_cnt[r]),
         .empty(sd_empty[r]), .full(sd_full[r]));

      ldsf_stream #(.AW(AW), .CW(CW)) u_eng (
         .clk(clk), .rst_n(rst_n), .start(start_r), .base(ld_base),
         .stride(ld_stride), .count(ld_count), .room(eng_room[r]),
         .grant(ld_grant[r]), .busy(ld_busy[r]), .req(eng_req[r]),
         .addr(eng_addr[r]));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            infl_q[r] <= '0;
         end else begin
            case ({ld_grant[r], ret})
               2'b10:   infl_q[r] <= infl_q[r] + LCW'(1);
               2'b01:   infl_q[r] <= infl_q[r] - LCW'(1);
               default: infl_q[r] <= infl_q[r];
            endcase
         end
      end

      AST_RESERVE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
         occ <= (LCW+1)'(LDEPTH)); // R3
      AST_FULL_NOTHING_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
         lf_full[r] |-> (infl_q[r] == '0)); // R3
      AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n)
         ret |-> (infl_q[r] != '0)); // R4
   end

   // arbitration: store first, then lowest-numbered stream
   always_comb begin
      src    = SRC_IDLE;
      ld_sel = '0;
      if (st_ready) begin
         src = SRC_STORE;
      end else begin
         for (int r = NREG-1; r >= 0; r--) begin
            if (eng_req[r]) begin
               src    = SRC_LOAD;
               ld_sel = RW'(r);
            end
         end
      end
   end

   always_comb begin
      ld_grant = '0;
      if (src == SRC_LOAD && mem_ack) ld_grant[ld_sel] = 1'b1;
   end

   always_comb begin
      mem_req   = (src != SRC_IDLE);
      mem_we    = (src == SRC_STORE);
      mem_tag   = (src == SRC_STORE) ? sa_head_reg : ld_sel;
      mem_addr  = (src == SRC_STORE) ? sa_head_addr : eng_addr[ld_sel];
      mem_wdata = (src == SRC_STORE) ? sd_head[sa_head_reg] : '0;
   end

   assign rd_data  = lf_head[rd_reg];
   assign rd_stall = rd_en && lf_empty[rd_reg];
   assign wr_stall = wr_en && sd_full[wr_reg];

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({st_grant, ld_grant})); // R8
   AST_STORE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> ((sa_cnt != '0) && (sd_cnt[mem_tag] != '0))); // R7
endmodule

// File: tb/ldsf_unit_tb.sv
`timescale 1ns/100ps
module ldsf_unit_tb;
   localparam int D = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ld_start;
   logic [0:0]  ld_reg;
   logic [31:0] ld_base, ld_stride;
   logic [15:0] ld_count;
   logic [1:0]  ld_busy;
   logic        sa_valid;
   logic [0:0]  sa_reg;
   logic [31:0] sa_addr;
   logic        sa_full;
   logic        rd_en;
   logic [0:0]  rd_reg;
   logic [31:0] rd_data;
   logic        rd_stall;
   logic        wr_en;
   logic [0:0]  wr_reg;
   logic [31:0] wr_data;
   logic        wr_stall;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [0:0]  mem_tag;
   logic        mem_ack, mem_rvalid;
   logic [0:0]  mem_rtag;
   logic [31:0] mem_rdata;

   always #2.5 clk = ~clk;

   ldsf_unit u_dut (
      .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_reg(ld_reg),
      .ld_base(ld_base), .ld_stride(ld_stride), .ld_count(ld_count),
      .ld_busy(ld_busy), .sa_valid(sa_valid), .sa_reg(sa_reg),
      .sa_addr(sa_addr), .sa_full(sa_full), .rd_en(rd_en), .rd_reg(rd_reg),
      .rd_data(rd_data), .rd_stall(rd_stall), .wr_en(wr_en), .wr_reg(wr_reg),
      .wr_data(wr_data), .wr_stall(wr_stall), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_tag(mem_tag), .mem_ack(mem_ack), .mem_rvalid(mem_rvalid),
      .mem_rtag(mem_rtag), .mem_rdata(mem_rdata));

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;

   // reference model state
   logic [31:0] m_lq  [2][$];
   logic [31:0] m_sdq [2][$];
   logic [31:0] m_saq_a [$];
   logic [0:0]  m_saq_r [$];
   logic [31:0] m_rq_d [$];
   logic [0:0]  m_rq_t [$];
   int          m_infl [2];
   int          m_rem  [2];
   logic [31:0] m_addr [2];
   logic [31:0] m_strd [2];

   function automatic logic [31:0] memval(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
   endfunction

   task automatic chk(input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s cycle %0d: actual %h expected %h", rq, what, cyc, act, exp);
      end
   endtask

   task automatic clear_inputs();
      ld_start = 0; ld_reg = 0; ld_base = 0; ld_stride = 0; ld_count = 0;
      sa_valid = 0; sa_reg = 0; sa_addr = 0;
      rd_en = 0; rd_reg = 0; wr_en = 0; wr_reg = 0; wr_data = 0;
   endtask

   task automatic tick();
      bit st_ok, e_req, e_we, grant;
      bit e_lreq [2];
      bit rd_ok, wr_ok, sa_ok, st_ok2;
      logic [0:0]  e_tag;
      logic [31:0] e_addr, e_wdata;
      // memory side drive
      mem_ack = ((cyc % 5) != 3);
      if (((cyc % 3) != 1) && m_rq_d.size() > 0) begin
         mem_rvalid = 1; mem_rtag = m_rq_t[0]; mem_rdata = m_rq_d[0];
      end else begin
         mem_rvalid = 0; mem_rtag = 0; mem_rdata = 0;
      end
      #1;
      // expected outputs of this cycle
      st_ok = (m_saq_a.size() > 0) && (m_sdq[m_saq_r[0]].size() > 0);
      for (int r = 0; r < 2; r++)
         e_lreq[r] = (m_rem[r] != 0) && ((m_lq[r].size() + m_infl[r]) < D);
      e_req = 0; e_we = 0; e_tag = 0; e_addr = 0; e_wdata = 0;
      if (st_ok) begin
         e_req = 1; e_we = 1; e_tag = m_saq_r[0]; e_addr = m_saq_a[0];
         e_wdata = m_sdq[m_saq_r[0]][0];
      end else if (e_lreq[0]) begin
         e_req = 1; e_tag = 0; e_addr = m_addr[0];
      end else if (e_lreq[1]) begin
         e_req = 1; e_tag = 1; e_addr = m_addr[1];
      end
      chk("R2", "ld_busy[0]", 32'(ld_busy[0]), 32'(m_rem[0] != 0));
      chk("R9", "ld_busy[1]", 32'(ld_busy[1]), 32'(m_rem[1] != 0));
      chk("R10", "sa_full", 32'(sa_full), 32'(m_saq_a.size() == D));
      chk("R5", "rd_stall", 32'(rd_stall), 32'(rd_en && m_lq[rd_reg].size() == 0));
      if (rd_en && m_lq[rd_reg].size() > 0)
         chk("R4", "rd_data", rd_data, m_lq[rd_reg][0]);
      chk("R6", "wr_stall", 32'(wr_stall), 32'(wr_en && m_sdq[wr_reg].size() == D));
      chk("R3", "mem_req", 32'(mem_req), 32'(e_req));
      if (e_req) begin
         chk("R7", "mem_we", 32'(mem_we), 32'(e_we));
         chk("R8", "mem_tag", 32'(mem_tag), 32'(e_tag));
         chk(e_we ? "R7" : "R2", "mem_addr", mem_addr, e_addr);
         if (e_we) chk("R7", "mem_wdata", mem_wdata, e_wdata);
      end
      // advance the model with pre-cycle decisions
      grant  = e_req && mem_ack;
      rd_ok  = rd_en && (m_lq[rd_reg].size() > 0);
      wr_ok  = wr_en && (m_sdq[wr_reg].size() < D);
      sa_ok  = sa_valid && (m_saq_a.size() < D);
      st_ok2 = grant && e_we;
      if (rd_ok) void'(m_lq[rd_reg].pop_front());
      if (mem_rvalid) begin
         m_lq[mem_rtag].push_back(mem_rdata);
         m_infl[mem_rtag]--;
         void'(m_rq_d.pop_front());
         void'(m_rq_t.pop_front());
      end
      if (st_ok2) begin
         void'(m_sdq[e_tag].pop_front());
         void'(m_saq_a.pop_front());
         void'(m_saq_r.pop_front());
      end else if (grant) begin
         m_infl[e_tag]++;
         m_rq_d.push_back(memval(m_addr[e_tag]));
         m_rq_t.push_back(e_tag);
         m_addr[e_tag] = m_addr[e_tag] + m_strd[e_tag];
         m_rem[e_tag]--;
      end
      if (wr_ok) m_sdq[wr_reg].push_back(wr_data);
      if (sa_ok) begin
         m_saq_a.push_back(sa_addr);
         m_saq_r.push_back(sa_reg);
      end
      if (ld_start && m_rem[ld_reg] == 0) begin
         m_rem[ld_reg]  = int'(ld_count);
         m_addr[ld_reg] = ld_base;
         m_strd[ld_reg] = ld_stride;
      end
      @(posedge clk);
      #0.5;
      clear_inputs();
      cyc++;
   endtask

   task automatic start_stream(input logic [0:0] r, input logic [31:0] b,
                               input logic [31:0] s, input int n);
      ld_start = 1; ld_reg = r; ld_base = b; ld_stride = s; ld_count = 16'(n);
      tick();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      clear_inputs();
      mem_ack = 0; mem_rvalid = 0; mem_rtag = 0; mem_rdata = 0;
      for (int r = 0; r < 2; r++) begin
         m_infl[r] = 0; m_rem[r] = 0; m_addr[r] = 0; m_strd[r] = 0;
      end
      rst_n = 0;
      repeat (3) @(posedge clk);
      #0.5;
      rst_n = 1;
      #1;
      // R1: reset state
      chk("R1", "mem_req", 32'(mem_req), 0);
      chk("R1", "ld_busy", 32'(ld_busy), 0);
      chk("R1", "sa_full", 32'(sa_full), 0);
      chk("R1", "rd_stall", 32'(rd_stall), 0);
      chk("R1", "wr_stall", 32'(wr_stall), 0);

      // R2/R3: stream of 6 into reg0, nobody reads, FIFO fills
      start_stream(0, 32'h0000_1000, 32'd4, 6);
      idle(12);
      #0.1;
      chk("R3", "busy while held", 32'(ld_busy[0]), 1);
      chk("R3", "no request when reserved", 32'(mem_req), 0);
      // R9: start while busy is ignored
      start_stream(0, 32'h0000_9000, 32'd8, 3);
      // R4/R5: read all six, including reads that stall
      for (int i = 0; i < 14; i++) begin
         rd_en = 1; rd_reg = 0; tick();
      end
      idle(3);
      // R8: two streams at once, negative stride on reg1
      start_stream(1, 32'h0000_2000, 32'hFFFF_FFF8, 5);
      start_stream(0, 32'h0000_3000, 32'd16, 3);
      start_stream(0, 32'h0000_5000, 32'd0, 0);
      for (int i = 0; i < 16; i++) begin
         rd_en = 1; rd_reg = 1'(i % 2); tick();
      end
      // R7: addresses before data
      sa_valid = 1; sa_reg = 1; sa_addr = 32'h0000_4000; tick();
      sa_valid = 1; sa_reg = 0; sa_addr = 32'h0000_4100; tick();
      sa_valid = 1; sa_reg = 1; sa_addr = 32'h0000_4200; tick();
      idle(3);
      wr_en = 1; wr_reg = 0; wr_data = 32'hAAAA_0001; tick();
      idle(2);
      wr_en = 1; wr_reg = 1; wr_data = 32'h1111_0002; tick();
      idle(4);
      // R6: overfill reg0 store data
      for (int i = 0; i < 6; i++) begin
         wr_en = 1; wr_reg = 0; wr_data = 32'hD000_0000 + 32'(i); tick();
      end
      // R10: overfill the address queue with reg1 addresses (no reg1 data)
      for (int i = 0; i < 6; i++) begin
         sa_valid = 1; sa_reg = 1; sa_addr = 32'h0000_6000 + 32'(i * 4); tick();
      end
      idle(2);
      // R8: stores and a stream compete
      start_stream(1, 32'h0000_7000, 32'd4, 4);
      for (int i = 0; i < 6; i++) begin
         wr_en = 1; wr_reg = 1; wr_data = 32'hE000_0000 + 32'(i);
         sa_valid = 1; sa_reg = 0; sa_addr = 32'h0000_8000 + 32'(i * 4);
         tick();
      end
      for (int i = 0; i < 30; i++) begin
         rd_en = 1; rd_reg = 1'(i % 2); tick();
      end
      idle(10);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule